// File: doc/BRIEF.md
# Network Adapter Control/Status and Parity Error Registers

This block holds the host-visible control word of a shared-memory network adapter. Software uses it to hold the network controller in reset, to pulse the controller's attention line, to switch the line interface between loopback and on-air operation, to enable an auxiliary memory bus, and to enable two interrupt sources. Reading the same word returns the live controller interrupt flag, the parity error flag, a RAM-size strap, and a strapped 4-bit value that software uses as address bits of the board RAM window.

When the RAM parity checker reports an error, the block captures a record of it: the 20-bit failing address, the source of the failing access, and which data half failed. Only the first error is kept. Later errors are ignored until the host writes the acknowledge bit in the parity control register. A single interrupt request combines the controller interrupt and the parity error, each with its own enable.

Registers are chosen by a 2-bit select: 0 is the control/status word, 1 is parity control, 2 is the low 16 bits of the failing address, and 3 is unused. Reads are combinational from the select. Writes take effect on the next rising clock edge.

Top module: `netif_ctl_regs`

## Requirements
- R1: After reset, all control bits are 0 and the record is empty. ctrl_rst_o, ctrl_attn_o, on_air_o, aux_en_o and irq_o are low. The status word reads only the straps: bit 4 = strap_big_ram_i, bits [3:0] = strap_haddr_i.
- R2: A write to select 0 loads the writable status bits on the next edge. These are bit 15 (controller reset → ctrl_rst_o), bit 14 (on-air → on_air_o), bit 13 (attention), bit 12 (controller interrupt enable), bit 11 (parity interrupt enable) and bit 5 (auxiliary bus enable → aux_en_o). Bits 10, 7 and 6 read as 0. Writes to the read-only bits 9, 8, 4 and [3:0] have no effect.
- R3: ctrl_attn_o follows status bit 13 while bit 15 is clear. It is forced low while bit 15 is set.
- R4: Status bit 8 reads the live ctrl_irq_i. Status bit 9 reads the parity error flag.
- R5: A parity error report (par_err_i high on an edge) with no record held sets the flag and captures the record. Select 1 then reads bit 7 = source, bit 6 = data half, bits [3:0] = address [19:16], and all other bits 0. Select 2 reads address [15:0].
- R6: While a record is held, further parity error reports leave the flag and the record unchanged.
- R7: A write to select 1 with bit 8 set clears the flag and the record on the next edge. Bit 8 always reads 0. A write to select 1 with bit 8 clear has no effect.
- R8: A parity error reported on the same edge as an acknowledge is captured as a new record.
- R9: irq_o is high exactly when (ctrl_irq_i and status bit 12) or (parity flag and status bit 11). It follows its inputs in the same cycle.
- R10: Select 3 reads 0. Writes to selects 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select (0 status, 1 parity ctrl, 2 address low, 3 none) |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| strap_haddr_i | input | 4 | Strapped RAM window address bits |
| strap_big_ram_i | input | 1 | Strap: larger RAM devices fitted |
| ctrl_irq_i | input | 1 | Interrupt flag from the network controller |
| par_err_i | input | 1 | Parity error report from the RAM checker |
| par_addr_i | input | 20 | Failing RAM address |
| par_src_i | input | 1 | Source of the failing access |
| par_half_i | input | 1 | Data half that failed |
| ctrl_rst_o | output | 1 | Network controller reset |
| ctrl_attn_o | output | 1 | Network controller attention |
| on_air_o | output | 1 | Leave loopback, drive the line |
| aux_en_o | output | 1 | Auxiliary memory bus enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The control word is written with all ones, with single bits and with reset and attention combined. This separates the writable bits from the read-only and reserved ones, and shows that reset masks attention. Parity errors arrive in four situations: alone, while a record is already held, alongside an acknowledge, and alongside a write whose acknowledge bit is clear. These separate first-error capture, freezing of the record, the collision rule and acknowledge decoding. The interrupt is tried with each enable set alone against each source alone, which exposes swapped or missing enables.

// File: rtl/netif_ctl_pkg.sv
package netif_ctl_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_PCTL = 2'd1,
    SEL_PADR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status word bit positions
  localparam int B_RST  = 15;
  localparam int B_AIR  = 14;
  localparam int B_ATN  = 13;
  localparam int B_IEN  = 12;
  localparam int B_PEN  = 11;
  localparam int B_PFLG = 9;
  localparam int B_IFLG = 8;
  localparam int B_AUX  = 5;
  localparam int B_BIG  = 4;

  // parity control bit positions
  localparam int P_ACK  = 8;
  localparam int P_SRC  = 7;
  localparam int P_HALF = 6;

  typedef struct packed {
    logic rst;
    logic air;
    logic atn;
    logic ien;
    logic pen;
    logic aux;
  } ctl_t;
endpackage

// File: rtl/netif_ctl_bits.sv
module netif_ctl_bits
  import netif_ctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctl_t              ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
    end else if (we_i) begin
      ctl_o.rst <= wdata_i[B_RST];
      ctl_o.air <= wdata_i[B_AIR];
      ctl_o.atn <= wdata_i[B_ATN];
      ctl_o.ien <= wdata_i[B_IEN];
      ctl_o.pen <= wdata_i[B_PEN];
      ctl_o.aux <= wdata_i[B_AUX];
    end
  end
endmodule

// File: rtl/netif_perr_capture.sv
module netif_perr_capture #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              src_i,
  input  logic              half_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              src_o,
  output logic              half_o
);
  logic load;

  // ack frees the slot; an error on the same edge takes it at once
  assign load = err_i && (ack_i || !valid_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      src_o   <= 1'b0;
      half_o  <= 1'b0;
    end else if (load) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      src_o   <= src_i;
      half_o  <= half_i;
    end else if (ack_i) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      src_o   <= 1'b0;
      half_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/netif_ctl_regs.sv
module netif_ctl_regs
  import netif_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HI_W   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             reg_sel_i,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic [HI_W-1:0]        strap_haddr_i,
  input  logic                   strap_big_ram_i,
  input  logic                   ctrl_irq_i,
  input  logic                   par_err_i,
  input  logic [DATA_W+HI_W-1:0] par_addr_i,
  input  logic                   par_src_i,
  input  logic                   par_half_i,
  output logic                   ctrl_rst_o,
  output logic                   ctrl_attn_o,
  output logic                   on_air_o,
  output logic                   aux_en_o,
  output logic                   irq_o
);
  localparam int ADDR_W = DATA_W + HI_W;

  ctl_t              ctl;
  logic              we_stat;
  logic              ack;
  logic              perr_valid;
  logic [ADDR_W-1:0] err_addr;
  logic              err_src;
  logic              err_half;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] pctl_word;

  assign we_stat = wr_en_i && (reg_sel_i == SEL_STAT);
  assign ack     = wr_en_i && (reg_sel_i == SEL_PCTL) && wdata_i[P_ACK];

  netif_ctl_bits #(.DATA_W(DATA_W)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_stat),
    .wdata_i (wdata_i),
    .ctl_o   (ctl)
  );

  netif_perr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (par_err_i),
    .addr_i  (par_addr_i),
    .src_i   (par_src_i),
    .half_i  (par_half_i),
    .ack_i   (ack),
    .valid_o (perr_valid),
    .addr_o  (err_addr),
    .src_o   (err_src),
    .half_o  (err_half)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[B_RST]  = ctl.rst;
    stat_word[B_AIR]  = ctl.air;
    stat_word[B_ATN]  = ctl.atn;
    stat_word[B_IEN]  = ctl.ien;
    stat_word[B_PEN]  = ctl.pen;
    stat_word[B_PFLG] = perr_valid;
    stat_word[B_IFLG] = ctrl_irq_i;
    stat_word[B_AUX]  = ctl.aux;
    stat_word[B_BIG]  = strap_big_ram_i;
    stat_word[HI_W-1:0] = strap_haddr_i;
  end

  always_comb begin
    pctl_word           = '0;
    pctl_word[P_SRC]    = err_src;
    pctl_word[P_HALF]   = err_half;
    pctl_word[HI_W-1:0] = err_addr[ADDR_W-1:DATA_W];
  end

  always_comb begin
    case (reg_sel_i)
      SEL_STAT: rdata_o = stat_word;
      SEL_PCTL: rdata_o = pctl_word;
      SEL_PADR: rdata_o = err_addr[DATA_W-1:0];
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_rst_o  = ctl.rst;
  assign ctrl_attn_o = ctl.atn && !ctl.rst;
  assign on_air_o    = ctl.air;
  assign aux_en_o    = ctl.aux;
  assign irq_o       = (ctrl_irq_i && ctl.ien) || (perr_valid && ctl.pen);
endmodule

// File: rtl/netif_ctl_regs_chk.sv
module netif_ctl_regs_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        reg_sel_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ctrl_irq_i,
  input logic              par_err_i,
  input logic              ctrl_rst_o,
  input logic              ctrl_attn_o,
  input logic              irq_o,
  input logic              perr_valid,
  input logic [ADDR_W-1:0] err_addr
);
  logic ack_w;
  assign ack_w = wr_en_i && (reg_sel_i == 2'd1) && wdata_i[8];

  AST_RST_MASKS_ATTN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |-> !ctrl_attn_o); // R3

  AST_STAT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == 2'd0) |=> (ctrl_rst_o == $past(wdata_i[15]))); // R2

  AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_i && !perr_valid) |=> perr_valid); // R5

  AST_RECORD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_valid && !ack_w) |=> (perr_valid && $stable(err_addr))); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !par_err_i) |=> (!perr_valid && err_addr == '0)); // R7

  AST_ACK_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && par_err_i) |=> perr_valid); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_irq_i && !perr_valid) |-> !irq_o); // R9
endmodule

bind netif_ctl_regs netif_ctl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_sel_i   (reg_sel_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .ctrl_irq_i  (ctrl_irq_i),
  .par_err_i   (par_err_i),
  .ctrl_rst_o  (ctrl_rst_o),
  .ctrl_attn_o (ctrl_attn_o),
  .irq_o       (irq_o),
  .perr_valid  (perr_valid),
  .err_addr    (err_addr)
);

// File: tb/tb_netif_ctl_regs.sv
`timescale 1ns/1ps
module tb_netif_ctl_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  strap_haddr_i = 4'hA;
  logic        strap_big_ram_i = 1'b1;
  logic        ctrl_irq_i = 1'b0;
  logic        par_err_i = 1'b0;
  logic [19:0] par_addr_i = '0;
  logic        par_src_i = 1'b0;
  logic        par_half_i = 1'b0;
  logic        ctrl_rst_o, ctrl_attn_o, on_air_o, aux_en_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  netif_ctl_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel_i = sel;
    #1 d = rdata_o;
  endtask

  task automatic perr(input logic [19:0] a, input logic s, input logic h);
    @(negedge clk_i);
    par_err_i = 1'b1; par_addr_i = a; par_src_i = s; par_half_i = h;
    @(negedge clk_i);
    par_err_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d);
    chk("R1 status", d, 16'h001A);
    chk("R1 outs", {ctrl_rst_o, ctrl_attn_o, on_air_o, aux_en_o, irq_o}, 5'b0);
    rd(2'd1, d); chk("R1 pctl", d, 16'h0);
    rd(2'd2, d); chk("R1 padr", d, 16'h0);
  endtask

  task automatic t_status_write();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d);
    chk("R2 status all ones", d, 16'hF83A);
    chk("R2 outs", {ctrl_rst_o, on_air_o, aux_en_o}, 3'b111);
    wr(2'd0, 16'h0000);
    rd(2'd0, d);
    chk("R2 cleared", d, 16'h001A);
    chk("R2 outs clr", {ctrl_rst_o, on_air_o, aux_en_o}, 3'b000);
  endtask

  task automatic t_attn();
    wr(2'd0, 16'h2000);
    chk("R3 attn up", ctrl_attn_o, 1'b1);
    wr(2'd0, 16'hA000);
    chk("R3 attn masked", ctrl_attn_o, 1'b0);
    chk("R3 rst", ctrl_rst_o, 1'b1);
    wr(2'd0, 16'h0000);
    chk("R3 attn down", ctrl_attn_o, 1'b0);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    @(negedge clk_i);
    ctrl_irq_i = 1'b1;
    rd(2'd0, d);
    chk("R4 irq flag", d, 16'h011A);
    ctrl_irq_i = 1'b0;
    rd(2'd0, d);
    chk("R4 irq flag clr", d, 16'h001A);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    perr(20'h51234, 1'b1, 1'b0);
    rd(2'd1, d); chk("R5 pctl", d, 16'h0085);
    rd(2'd2, d); chk("R5 padr", d, 16'h1234);
    rd(2'd0, d); chk("R4 perr flag", d, 16'h021A);
  endtask

  task automatic t_freeze();
    logic [15:0] d;
    perr(20'h3ABCD, 1'b0, 1'b1);
    rd(2'd1, d); chk("R6 pctl frozen", d, 16'h0085);
    rd(2'd2, d); chk("R6 padr frozen", d, 16'h1234);
  endtask

  task automatic t_ack();
    logic [15:0] d;
    wr(2'd1, 16'hFEFF);
    rd(2'd1, d); chk("R7 no-ack keeps", d, 16'h0085);
    rd(2'd0, d); chk("R7 flag kept", d, 16'h021A);
    wr(2'd1, 16'h0100);
    rd(2'd1, d); chk("R7 pctl clr", d, 16'h0000);
    rd(2'd2, d); chk("R7 padr clr", d, 16'h0000);
    rd(2'd0, d); chk("R7 flag clr", d, 16'h001A);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    perr(20'h2AAAA, 1'b0, 1'b0);
    @(negedge clk_i);
    reg_sel_i = 2'd1; wdata_i = 16'h0100; wr_en_i = 1'b1;
    par_err_i = 1'b1; par_addr_i = 20'hC5555; par_src_i = 1'b1; par_half_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; par_err_i = 1'b0;
    rd(2'd1, d); chk("R8 pctl new", d, 16'h00CC);
    rd(2'd2, d); chk("R8 padr new", d, 16'h5555);
    wr(2'd1, 16'h0100);
  endtask

  task automatic t_irq();
    wr(2'd0, 16'h1000);
    ctrl_irq_i = 1'b1; #1 chk("R9 ien src", irq_o, 1'b1);
    ctrl_irq_i = 1'b0; #1 chk("R9 ien idle", irq_o, 1'b0);
    wr(2'd0, 16'h0800);
    ctrl_irq_i = 1'b1; #1 chk("R9 pen ignores ctrl", irq_o, 1'b0);
    ctrl_irq_i = 1'b0;
    perr(20'h00001, 1'b0, 1'b0);
    #1 chk("R9 pen perr", irq_o, 1'b1);
    wr(2'd0, 16'h1000);
    #1 chk("R9 ien ignores perr", irq_o, 1'b0);
    wr(2'd1, 16'h0100);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    perr(20'h97777, 1'b1, 1'b1);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk("R10 sel3 zero", d, 16'h0000);
    rd(2'd2, d); chk("R10 padr kept", d, 16'h7777);
    rd(2'd1, d); chk("R10 pctl kept", d, 16'h00C9);
    rd(2'd0, d); chk("R10 status kept", d, 16'h021A);
  endtask

  initial begin
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_status_write();
    t_attn();
    t_flags();
    t_capture();
    t_freeze();
    t_ack();
    t_collide();
    t_irq();
    t_regmap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule